// File: doc/BRIEF.md
# Display DMA Interrupt Status Controller

This block gathers event pulses from up to seven display DMA channels and condenses them into one level-sensitive interrupt line. The events arrive one per cycle. Each event carries a kind code, a channel number and the frame ID of the descriptor that channel is working on. Start-of-frame and end-of-frame events also carry the two interrupt-enable bits taken from that descriptor's command word. The block keeps two status registers, a control word and a per-channel mask word. It also keeps an interrupt-ID register. Software reads this register to learn which frame raised the line.

Software programs the control word and the channel mask word through a single-cycle register write port. The same port also acknowledges status bits by writing ones to them. The interrupt line follows the status and mask registers directly, so it moves in the same cycle as any status change. The block latches the frame ID only when the line is low at the moment an unmasked source fires. If the line is already high, the block sets a "subsequent interrupt" flag instead. Software can then tell that more than one source fired.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset, status 0, status 1, the control word, the channel mask word and the interrupt ID are all zero, and `irq` is low.
- R2: Event kind codes are: 0 start-of-frame, 1 end-of-frame, 2 branch taken, 3 bus error, 4 read status, 5 last-frame done. Codes 6 and 7 are ignored, and so is any event whose channel is NUM_CH or higher. Channel 0 events go to status 0: start-of-frame sets bit 1, end-of-frame sets bit 8 and branch sets bit 9. For a channel n from 1 to 6, the same events set status 1 bits n-1, n+7 and n+15.
- R3: A start-of-frame event is recorded only if `ev_cmd_ie[1]` is set (command word bit 22). An end-of-frame event is recorded only if `ev_cmd_ie[0]` is set (command word bit 21). A branch event is always recorded.
- R4: A write to address 0 (control) keeps bit 31 (controller enable) and bits 11:0 (status-0 masks, one per status-0 bit position). A write to address 1 (channel masks) keeps only the bits in 0x3F3F3F3F. Channel n uses the same bit positions as its status-1 bits.
- R5: `irq` is the OR of three groups of terms. Each status-0 bit in 11:0 except bit 10 counts when its control mask bit is clear. Bit 2 (bus error) always counts, whatever its mask. Each status-1 bit counts when its channel mask bit is clear. `irq` changes in the same cycle as the status or mask register it depends on.
- R6: When an unmasked start-of-frame, end-of-frame or branch event is recorded, the outcome depends on `irq` in that cycle. If `irq` is low, the interrupt ID takes `ev_fid`. If `irq` is high, status 0 bit 10 is set and the ID is unchanged. A masked event does neither.
- R7: A bus error sets status 0 bit 2 and stores the channel number in bits 30:28. For the ID-or-flag choice of R6 it always counts as unmasked.
- R8: A read-status event sets status 0 bit 11. It also sets bit 10 if `irq` is high and control bit 11 is clear. It never loads the ID. A last-frame-done event sets status 0 bit 0 and nothing else.
- R9: A write to address 2 clears the status-0 bits within 11:0 that are written as one. Writing one to bit 2 also clears bits 30:28.
- R10: A write to address 3 clears the status-1 bits that are written as one, limited to the mask 0x3E3F3F. Bit 16 (channel 1 branch) is therefore not cleared.
- R11: A control write that changes the enable bit 31 from 1 to 0 sets status 0 bit 7 (quick disable done).
- R12: When an event sets a status bit in the same cycle as a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 3 | Event kind code (R2) |
| ev_chan | input | 3 | Channel that raised the event |
| ev_fid | input | ID_W | Frame ID of that channel's current descriptor |
| ev_cmd_ie | input | 2 | Descriptor enables: [1] start-of-frame, [0] end-of-frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 channel masks, 2 clear status 0, 3 clear status 1 |
| wr_data | input | 32 | Write data |
| stat0 | output | 32 | Status register 0 |
| stat1 | output | 32 | Status register 1 |
| ctrl | output | 32 | Control word (enable and status-0 masks) |
| ch_mask | output | 32 | Channel mask word |
| int_id | output | ID_W | Captured frame ID |
| irq | output | 1 | Level interrupt |

## Verification
Every event and write takes effect at the first rising edge after it is applied. The status registers, the ID register and the mask registers all show the result right after that edge, and `irq` follows at once because it decodes those registers. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It compares all outputs at that second falling edge, one full edge after the change is due. The set-versus-clear case drives an event and a write in the same cycle and checks the surviving bit at that same point.

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl #(
  parameter int NUM_CH = 7,
  parameter int ID_W   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  logic [2:0]      ev_kind,
  input  logic [2:0]      ev_chan,
  input  logic [ID_W-1:0] ev_fid,
  input  logic [1:0]      ev_cmd_ie,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [31:0]     wr_data,
  output logic [31:0]     stat0,
  output logic [31:0]     stat1,
  output logic [31:0]     ctrl,
  output logic [31:0]     ch_mask,
  output logic [ID_W-1:0] int_id,
  output logic            irq
);

  localparam logic [2:0]  K_SOF = 3'd0, K_EOF = 3'd1, K_BR = 3'd2,
                          K_BER = 3'd3, K_RD = 3'd4, K_LF = 3'd5;
  localparam logic [1:0]  A_CTRL = 2'd0, A_MASK = 2'd1, A_CLR0 = 2'd2, A_CLR1 = 2'd3;
  localparam logic [31:0] MASK_KEEP = 32'h3F3F_3F3F;
  localparam logic [31:0] CLR1_KEEP = 32'h003E_3F3F;
  localparam logic [11:0] S0_GATED  = 12'hBFB;
  localparam logic [11:0] S0_FORCED = 12'h004;

  logic            en_q;
  logic [11:0]     cmask_q;
  logic [31:0]     chmask_q;
  logic [11:0]     s0_q;
  logic [2:0]      s0_ch_q;
  logic [31:0]     s1_q;
  logic [ID_W-1:0] id_q;

  logic [11:0] ev0_set, s0_set, s0_clr;
  logic [31:0] s1_set, s1_clr;
  logic        gated, ber, rd, unm, sint, cap, qd;

  wire ev_ok = ev_valid && (int'(ev_chan) < NUM_CH);
  wire ch0   = (ev_chan == 3'd0);

  assign irq = |(s0_q & ((~cmask_q & S0_GATED) | S0_FORCED)) | |(s1_q & ~chmask_q);

  always_comb begin
    ev0_set = '0;
    s1_set  = '0;
    gated   = 1'b0;
    ber     = 1'b0;
    rd      = 1'b0;
    if (ev_ok) begin
      case (ev_kind)
        K_SOF: if (ev_cmd_ie[1]) begin
          gated = 1'b1;
          if (ch0) ev0_set[1] = 1'b1;
          else     s1_set = 32'd1 << (ev_chan - 3'd1);
        end
        K_EOF: if (ev_cmd_ie[0]) begin
          gated = 1'b1;
          if (ch0) ev0_set[8] = 1'b1;
          else     s1_set = 32'd1 << (5'(ev_chan) + 5'd7);
        end
        K_BR: begin
          gated = 1'b1;
          if (ch0) ev0_set[9] = 1'b1;
          else     s1_set = 32'd1 << (5'(ev_chan) + 5'd15);
        end
        K_BER: begin
          ber        = 1'b1;
          ev0_set[2] = 1'b1;
        end
        K_RD: begin
          rd          = 1'b1;
          ev0_set[11] = 1'b1;
        end
        K_LF: ev0_set[0] = 1'b1;
        default: ;
      endcase
    end
    unm  = ber || (gated && (|(ev0_set & ~cmask_q) || |(s1_set & ~chmask_q)));
    sint = (unm && irq) || (rd && irq && !cmask_q[11]);
    cap  = unm && !irq;
    qd   = wr_en && (wr_addr == A_CTRL) && en_q && !wr_data[31];
    s0_set     = ev0_set;
    s0_set[10] = ev0_set[10] | sint;
    s0_set[7]  = ev0_set[7] | qd;
  end

  assign s0_clr = (wr_en && wr_addr == A_CLR0) ? wr_data[11:0] : 12'd0;
  assign s1_clr = (wr_en && wr_addr == A_CLR1) ? (wr_data & CLR1_KEEP) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cmask_q  <= '0;
      chmask_q <= '0;
      s0_q     <= '0;
      s0_ch_q  <= '0;
      s1_q     <= '0;
      id_q     <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        en_q    <= wr_data[31];
        cmask_q <= wr_data[11:0];
      end
      if (wr_en && wr_addr == A_MASK)
        chmask_q <= wr_data & MASK_KEEP;
      s0_q <= (s0_q & ~s0_clr) | s0_set;
      if (ber)            s0_ch_q <= ev_chan;
      else if (s0_clr[2]) s0_ch_q <= '0;
      s1_q <= (s1_q & ~s1_clr) | s1_set;
      if (cap) id_q <= ev_fid;
    end
  end

  assign stat0   = {1'b0, s0_ch_q, 16'd0, s0_q};
  assign stat1   = s1_q;
  assign ctrl    = {en_q, 19'd0, cmask_q};
  assign ch_mask = chmask_q;
  assign int_id  = id_q;

endmodule

// File: rtl/disp_irq_ctrl_chk.sv
module disp_irq_ctrl_chk #(
  parameter int NUM_CH = 7,
  parameter int ID_W   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic [2:0]      ev_kind,
  input logic [2:0]      ev_chan,
  input logic [ID_W-1:0] ev_fid,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic            wr_msb,
  input logic            en_bit,
  input logic [31:0]     stat0,
  input logic [31:0]     stat1,
  input logic [31:0]     ch_mask,
  input logic [ID_W-1:0] int_id,
  input logic            irq
);

  wire ber_ev = ev_valid && ev_kind == 3'd3 && (int'(ev_chan) < NUM_CH);

  // R1 R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0 == 32'd0 && stat1 == 32'd0) |-> !irq);

  // R4
  mask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_mask & ~32'h3F3F_3F3F) == 32'd0);

  // R2
  stat1_holes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat1 & 32'hFFC0_C0C0) == 32'd0);

  // R7
  ber_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ber_ev |=> (stat0[2] && stat0[30:28] == $past(ev_chan)));

  // R6
  id_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ber_ev && !irq) |=> int_id == $past(ev_fid));

  // R6 R12
  subseq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ber_ev && irq) |=> (stat0[10] && $stable(int_id)));

  // R11
  quick_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && en_bit && !wr_msb) |=> stat0[7]);

endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
  .ev_chan(ev_chan), .ev_fid(ev_fid), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_msb(wr_data[31]), .en_bit(ctrl[31]), .stat0(stat0), .stat1(stat1),
  .ch_mask(ch_mask), .int_id(int_id), .irq(irq)
);

// File: tb/disp_irq_ctrl_test.sv
module disp_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_kind = '0;
  logic [2:0]  ev_chan = '0;
  logic [31:0] ev_fid = '0;
  logic [1:0]  ev_cmd_ie = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] stat0, stat1, ctrl, ch_mask, int_id;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_irq_ctrl #(.NUM_CH(7), .ID_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_chan(ev_chan), .ev_fid(ev_fid), .ev_cmd_ie(ev_cmd_ie),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat0(stat0), .stat1(stat1), .ctrl(ctrl), .ch_mask(ch_mask),
    .int_id(int_id), .irq(irq)
  );

  typedef struct packed {
    logic        is_wr;
    logic [2:0]  kind;
    logic [2:0]  chan;
    logic [1:0]  addr;
    logic [31:0] dat;
    logic [1:0]  ie;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [31:0] eid;
    logic        eirq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd0, 3'd0, 2'd0, 32'hA1, 2'b10, 32'h2, 32'h0, 32'hA1, 1'b1},           // R2 R6 sof ch0 captures
    '{1'b0, 3'd1, 3'd3, 2'd0, 32'hB3, 2'b01, 32'h402, 32'h400, 32'hA1, 1'b1},       // R2 R6 eof ch3 flag
    '{1'b1, 3'd0, 3'd0, 2'd2, 32'hFFF, 2'b00, 32'h0, 32'h400, 32'hA1, 1'b1},        // R9
    '{1'b1, 3'd0, 3'd0, 2'd3, 32'hFFFF_FFFF, 2'b00, 32'h0, 32'h0, 32'hA1, 1'b0},    // R10
    '{1'b0, 3'd0, 3'd2, 2'd0, 32'hC2, 2'b01, 32'h0, 32'h0, 32'hA1, 1'b0},           // R3 sof disabled
    '{1'b0, 3'd1, 3'd0, 2'd0, 32'hC0, 2'b10, 32'h0, 32'h0, 32'hA1, 1'b0},           // R3 eof disabled
    '{1'b1, 3'd0, 3'd0, 2'd1, 32'hFFFF_FFFF, 2'b00, 32'h0, 32'h0, 32'hA1, 1'b0},    // R4 mask all
    '{1'b0, 3'd2, 3'd1, 2'd0, 32'hC1, 2'b00, 32'h0, 32'h1_0000, 32'hA1, 1'b0},      // R6 masked branch
    '{1'b1, 3'd0, 3'd0, 2'd3, 32'hFFFF_FFFF, 2'b00, 32'h0, 32'h1_0000, 32'hA1, 1'b0}, // R10 bit16 kept
    '{1'b1, 3'd0, 3'd0, 2'd1, 32'h0, 2'b00, 32'h0, 32'h1_0000, 32'hA1, 1'b1},       // R5 unmask
    '{1'b0, 3'd3, 3'd5, 2'd0, 32'hD5, 2'b00, 32'h5000_0404, 32'h1_0000, 32'hA1, 1'b1}, // R7 flag
    '{1'b1, 3'd0, 3'd0, 2'd2, 32'h4, 2'b00, 32'h400, 32'h1_0000, 32'hA1, 1'b1},     // R9 ber clears chan
    '{1'b1, 3'd0, 3'd0, 2'd0, 32'h8000_0000, 2'b00, 32'h400, 32'h1_0000, 32'hA1, 1'b1}, // R11 enable
    '{1'b1, 3'd0, 3'd0, 2'd0, 32'h0, 2'b00, 32'h480, 32'h1_0000, 32'hA1, 1'b1},     // R11 quick disable
    '{1'b1, 3'd0, 3'd0, 2'd2, 32'hFFF, 2'b00, 32'h0, 32'h1_0000, 32'hA1, 1'b1},     // R9
    '{1'b1, 3'd0, 3'd0, 2'd1, 32'h1_0000, 2'b00, 32'h0, 32'h1_0000, 32'hA1, 1'b0},  // R5 mask bit16
    '{1'b0, 3'd3, 3'd6, 2'd0, 32'hE6, 2'b00, 32'h6000_0004, 32'h1_0000, 32'hE6, 1'b1}, // R7 capture
    '{1'b1, 3'd0, 3'd0, 2'd0, 32'h4, 2'b00, 32'h6000_0004, 32'h1_0000, 32'hE6, 1'b1}, // R5 ber unmaskable
    '{1'b0, 3'd4, 3'd0, 2'd0, 32'hF0, 2'b00, 32'h6000_0C04, 32'h1_0000, 32'hE6, 1'b1}, // R8 rdst flag
    '{1'b1, 3'd0, 3'd0, 2'd2, 32'hFFF, 2'b00, 32'h0, 32'h1_0000, 32'hE6, 1'b0},     // R9
    '{1'b0, 3'd5, 3'd0, 2'd0, 32'h99, 2'b00, 32'h1, 32'h1_0000, 32'hE6, 1'b1},      // R8 last frame
    '{1'b1, 3'd0, 3'd0, 2'd0, 32'h1, 2'b00, 32'h1, 32'h1_0000, 32'hE6, 1'b0},       // R5 mask bit0
    '{1'b0, 3'd4, 3'd0, 2'd0, 32'h77, 2'b00, 32'h801, 32'h1_0000, 32'hE6, 1'b1},    // R8 no capture
    '{1'b0, 3'd2, 3'd7, 2'd0, 32'h55, 2'b00, 32'h801, 32'h1_0000, 32'hE6, 1'b1}     // R2 bad channel
  };
  localparam int REQ [NV] = '{6, 6, 9, 10, 3, 3, 4, 6, 10, 5, 7, 9,
                              11, 11, 9, 5, 7, 5, 8, 9, 8, 5, 8, 2};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic is_wr, input logic [2:0] kind, input logic [2:0] chan,
                       input logic [1:0] addr, input logic [31:0] dat, input logic [1:0] ie,
                       input logic do_both);
    @(negedge clk);
    if (!is_wr || do_both) begin
      ev_valid = 1'b1; ev_kind = kind; ev_chan = chan; ev_fid = dat; ev_cmd_ie = ie;
    end
    if (is_wr || do_both) begin
      wr_en = 1'b1; wr_addr = addr; wr_data = is_wr ? dat : 32'hFFF;
    end
    @(negedge clk);
    ev_valid = 1'b0; wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 stat0", stat0, 32'h0);
    chk("R1 stat1", stat1, 32'h0);
    chk("R1 ctrl", ctrl, 32'h0);
    chk("R1 ch_mask", ch_mask, 32'h0);
    chk("R1 int_id", int_id, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].is_wr, TBL[i].kind, TBL[i].chan, TBL[i].addr, TBL[i].dat, TBL[i].ie, 1'b0);
      checks++;
      if (stat0 !== TBL[i].e0 || stat1 !== TBL[i].e1 || int_id !== TBL[i].eid || irq !== TBL[i].eirq) begin
        failures++;
        $display("FAIL R%0d row %0d actual s0=%h s1=%h id=%h irq=%b expected s0=%h s1=%h id=%h irq=%b",
                 REQ[i], i, stat0, stat1, int_id, irq, TBL[i].e0, TBL[i].e1, TBL[i].eid, TBL[i].eirq);
      end
    end

    // R4 register write masks
    apply(1'b1, 3'd0, 3'd0, 2'd1, 32'hFFFF_FFFF, 2'b00, 1'b0);
    chk("R4 ch_mask keep", ch_mask, 32'h3F3F_3F3F);
    apply(1'b1, 3'd0, 3'd0, 2'd0, 32'hFFFF_FFFF, 2'b00, 1'b0);
    chk("R4 ctrl keep", ctrl, 32'h8000_0FFF);
    chk("R5 all masked irq", {31'd0, irq}, 32'h0);

    // R12 branch ch0 set together with clear of status 0 (0xFFF)
    apply(1'b0, 3'd2, 3'd0, 2'd2, 32'h12, 2'b00, 1'b1);
    chk("R12 set wins", stat0, 32'h200);
    chk("R12 id kept", int_id, 32'hE6);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule